// File: doc/BRIEF.md
# Lithium Cell Charge Sequencer

This block steps a single-cell lithium battery through one charge cycle. It takes comparator flags that are already deglitched: cell below the precharge level, cell below the recharge level, end-of-charge current seen, temperature outside the window, and thermal regulation active. It also takes a charge enable and a timer-off strap. From these it issues one phase command at a time (low-current conditioning, full-rate charge, or off), drives a small detection current after a timeout, and sets two open-drain status sinks. The current and voltage loops are analog and sit outside this block.

Two safety timers guard the cycle. The conditioning window is one tenth of the full-rate window. Both count ticks from a fractional-rate generator. Each cycle the generator adds `rate_scale + 1` to an 8-bit accumulator and emits a tick on overflow. The analog side lowers `rate_scale` when it cuts the charge current, so the windows stretch in proportion. While the temperature is out of range the timers freeze and keep their counts. After a timeout the block recovers without software. It either waits for the cell to sag below the recharge level, or it first drives the detection current until the cell rises above that level.

Top module: `chg_seq`

## Requirements
- R1: After reset, and in every cycle after a cycle with `chg_en` low, `cmd_pre`, `cmd_fast` and `flt_cur_en` are 0, `cmd_off` is 1 and both status sinks are off. Dropping `chg_en` clears any timeout fault.
- R2: When enabled with `bat_low` high, the block enters conditioning one cycle later (`cmd_pre`=1). The conditioning window is PRE_TICKS = FAST_TICKS/10 ticks, counted from entry. If `bat_low` is still high once the window has fully elapsed, the block enters the timeout fault on the next cycle.
- R3: When `bat_low` falls during conditioning, the block moves to full-rate charge (`cmd_fast`=1) and restarts the timer. Full-rate charge times out after FAST_TICKS ticks.
- R4: Full-rate charge ends in the done state only in a cycle where `term_det`=1, `bat_below_rch`=0, `therm_reg`=0 and `tmr_off`=0.
- R5: In the done state, `bat_below_rch`=1 starts a new cycle. The new cycle is conditioning if `bat_low`=1 and full-rate otherwise.
- R6: `temp_fault` during conditioning or full-rate charge turns both commands off and both sinks off in the same cycle. It holds the state and the timer count, so a suspension longer than the full window causes no timeout. Charging resumes when the flag clears.
- R7: Status sinks (`stat1_on`, `stat2_on`, where 1 means the sink conducts): conditioning 1/1, full-rate 1/0, done 0/1. Idle, suspension and either fault state give 0/0.
- R8: On a timeout with `bat_below_rch`=0, the block enters a fault wait with `flt_cur_en`=0. It restarts a new cycle once `bat_below_rch` is 1.
- R9: On a timeout with `bat_below_rch`=1, the block drives `flt_cur_en`=1 until a cycle with `bat_below_rch`=0. It then moves to the fault wait of R8.
- R10: With `tmr_off`=1, neither window times out and termination never completes. Asserting `tmr_off` in a fault state restarts a new cycle on the next clock.
- R11: Timer ticks occur at a rate of (`rate_scale`+1)/256 per cycle. With `rate_scale`=255 the windows last exactly their tick counts in cycles; with 127 they last twice as long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chg_en | input | 1 | Charge enable |
| tmr_off | input | 1 | Removes safety timers and termination |
| bat_low | input | 1 | Cell below precharge level |
| bat_below_rch | input | 1 | Cell below recharge level |
| term_det | input | 1 | Charge current at end-of-charge level |
| temp_fault | input | 1 | Cell temperature outside allowed window |
| therm_reg | input | 1 | Die thermal regulation active |
| rate_scale | input | SCALE_W | Timer rate, full scale = nominal |
| cmd_pre | output | 1 | Conditioning current command |
| cmd_fast | output | 1 | Full-rate charge command |
| cmd_off | output | 1 | Charge path off |
| flt_cur_en | output | 1 | Fault detection current enable |
| stat1_on | output | 1 | Status sink 1 conducting |
| stat2_on | output | 1 | Status sink 2 conducting |

## Verification
Two functions can fall in the same cycle: a temperature suspension and the expiry of the full-rate window. The bench holds `temp_fault` across more cycles than the whole window. It then judges that no fault current or fault status appears and that full-rate charge resumes. A second coincidence is termination and thermal regulation being reported together. The bench raises both flags at once and requires that charge continues, then drops only regulation and requires the done status on the next cycle.

// File: rtl/chg_pkg.sv
package chg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRE   = 3'd1,
    ST_FAST  = 3'd2,
    ST_DONE  = 3'd3,
    ST_FWAIT = 3'd4,
    ST_FDET  = 3'd5
  } chg_state_e;
endpackage

// File: rtl/chg_tick_gen.sv
// Fractional-rate tick source: adds scale+1 per cycle, ticks on overflow.
module chg_tick_gen #(
  parameter int SCALE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [SCALE_W-1:0] scale,
  output logic               tick
);
  logic [SCALE_W-1:0] acc_q;
  logic [SCALE_W:0]   sum;

  always_comb begin
    sum  = {1'b0, acc_q} + {1'b0, scale} + {{SCALE_W{1'b0}}, 1'b1};
    tick = sum[SCALE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc_q <= '0;
    else if (clr) acc_q <= '0;
    else          acc_q <= sum[SCALE_W-1:0];
  end
endmodule

// File: rtl/chg_safety_timer.sv
// Saturating tick counter with a window that depends on the phase.
module chg_safety_timer #(
  parameter int FAST_TICKS = 40,
  parameter int PRE_TICKS  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  input  logic is_pre,
  output logic expired
);
  localparam int CW = $clog2(FAST_TICKS + 1);
  localparam logic [CW-1:0] FAST_LIM = CW'(FAST_TICKS);
  localparam logic [CW-1:0] PRE_LIM  = CW'(PRE_TICKS);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  always_comb begin
    lim     = is_pre ? PRE_LIM : FAST_LIM;
    expired = (cnt_q >= lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr)              cnt_q <= '0;
    else if (adv && !expired)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/chg_status_enc.sv
// Maps the sequencer state and suspension to commands and status sinks.
module chg_status_enc
  import chg_pkg::*;
(
  input  chg_state_e state,
  input  logic       suspend,
  output logic       cmd_pre,
  output logic       cmd_fast,
  output logic       cmd_off,
  output logic       flt_cur_en,
  output logic       stat1_on,
  output logic       stat2_on
);
  always_comb begin
    cmd_pre    = (state == ST_PRE)  && !suspend;
    cmd_fast   = (state == ST_FAST) && !suspend;
    cmd_off    = !(cmd_pre || cmd_fast);
    flt_cur_en = (state == ST_FDET);
    stat1_on   = cmd_pre || cmd_fast;
    stat2_on   = cmd_pre || (state == ST_DONE);
  end
endmodule

// File: rtl/chg_seq.sv
module chg_seq
  import chg_pkg::*;
#(
  parameter int FAST_TICKS = 40,
  parameter int SCALE_W    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chg_en,
  input  logic               tmr_off,
  input  logic               bat_low,
  input  logic               bat_below_rch,
  input  logic               term_det,
  input  logic               temp_fault,
  input  logic               therm_reg,
  input  logic [SCALE_W-1:0] rate_scale,
  output logic               cmd_pre,
  output logic               cmd_fast,
  output logic               cmd_off,
  output logic               flt_cur_en,
  output logic               stat1_on,
  output logic               stat2_on
);
  localparam int PRE_TICKS = (FAST_TICKS / 10 > 0) ? FAST_TICKS / 10 : 1;

  chg_state_e state_q, state_d, restart_st, fault_st;
  logic       charging, suspend, tmr_clr, tick, expired, adv;

  always_comb begin
    charging   = (state_q == ST_PRE) || (state_q == ST_FAST);
    suspend    = charging && temp_fault;
    restart_st = bat_low ? ST_PRE : ST_FAST;
    fault_st   = bat_below_rch ? ST_FDET : ST_FWAIT;
    state_d    = state_q;
    if (!chg_en) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: state_d = restart_st;
        ST_PRE: if (!temp_fault) begin
          if (!bat_low)                 state_d = ST_FAST;
          else if (!tmr_off && expired) state_d = fault_st;
        end
        ST_FAST: if (!temp_fault) begin
          if (!tmr_off && term_det && !bat_below_rch && !therm_reg)
            state_d = ST_DONE;
          else if (!tmr_off && expired)
            state_d = fault_st;
        end
        ST_DONE:  if (bat_below_rch) state_d = restart_st;
        ST_FWAIT: if (tmr_off || bat_below_rch) state_d = restart_st;
        ST_FDET: begin
          if (tmr_off)             state_d = restart_st;
          else if (!bat_below_rch) state_d = ST_FWAIT;
        end
        default: state_d = ST_IDLE;
      endcase
    end
    tmr_clr = (state_d != state_q);
    adv     = tick && charging && !temp_fault;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  chg_tick_gen #(.SCALE_W(SCALE_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .scale(rate_scale), .tick(tick)
  );

  chg_safety_timer #(.FAST_TICKS(FAST_TICKS), .PRE_TICKS(PRE_TICKS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .adv(adv),
    .is_pre(state_q == ST_PRE), .expired(expired)
  );

  chg_status_enc u_enc (
    .state(state_q), .suspend(suspend),
    .cmd_pre(cmd_pre), .cmd_fast(cmd_fast), .cmd_off(cmd_off),
    .flt_cur_en(flt_cur_en), .stat1_on(stat1_on), .stat2_on(stat2_on)
  );
endmodule

// File: rtl/chg_seq_chk.sv
module chg_seq_chk #(
  parameter int SCALE_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               chg_en,
  input logic               tmr_off,
  input logic               bat_low,
  input logic               bat_below_rch,
  input logic               term_det,
  input logic               temp_fault,
  input logic               therm_reg,
  input logic [SCALE_W-1:0] rate_scale,
  input logic               cmd_pre,
  input logic               cmd_fast,
  input logic               cmd_off,
  input logic               flt_cur_en,
  input logic               stat1_on,
  input logic               stat2_on
);
  AST_EN_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !chg_en |=> (!cmd_pre && !cmd_fast && !flt_cur_en && cmd_off)); // R1
  AST_SUSPEND_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    temp_fault |-> (!cmd_pre && !cmd_fast)); // R6
  AST_PRE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pre |-> (stat1_on && stat2_on)); // R7
  AST_DONE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(!stat1_on && stat2_on) |->
      $past(term_det && !bat_below_rch && !therm_reg && !tmr_off)); // R4
  AST_DET_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_cur_en && !bat_below_rch) |=> !flt_cur_en); // R9
  AST_TOFF_NO_FLT: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_off |=> !flt_cur_en); // R10
endmodule

bind chg_seq chg_seq_chk #(.SCALE_W(SCALE_W)) u_chk (.*);

// File: tb/tb_chg_seq.sv
module tb_chg_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chg_en = 0, tmr_off = 0, bat_low = 0, bat_below_rch = 0;
  logic term_det = 0, temp_fault = 0, therm_reg = 0;
  logic [7:0] rate_scale = 8'd255;
  logic cmd_pre, cmd_fast, cmd_off, flt_cur_en, stat1_on, stat2_on;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  chg_seq #(.FAST_TICKS(40), .SCALE_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .chg_en(chg_en), .tmr_off(tmr_off),
    .bat_low(bat_low), .bat_below_rch(bat_below_rch), .term_det(term_det),
    .temp_fault(temp_fault), .therm_reg(therm_reg), .rate_scale(rate_scale),
    .cmd_pre(cmd_pre), .cmd_fast(cmd_fast), .cmd_off(cmd_off),
    .flt_cur_en(flt_cur_en), .stat1_on(stat1_on), .stat2_on(stat2_on)
  );

  // Row: {req, en, toff, blow, brch, term, temp, treg, hold, {pre,fast,flt,s1,s2}}
  localparam int NV = 13;
  localparam logic [23:0] VEC [NV] = '{
    {4'd1, 7'b0000000, 8'd2,  5'b00000}, // R1 disabled idle
    {4'd2, 7'b1011000, 8'd2,  5'b10011}, // R2 conditioning
    {4'd3, 7'b1001000, 8'd2,  5'b01010}, // R3 to full rate
    {4'd4, 7'b1000101, 8'd2,  5'b01010}, // R4 termination blocked by regulation
    {4'd4, 7'b1000100, 8'd2,  5'b00001}, // R4 done
    {4'd5, 7'b1000000, 8'd3,  5'b00001}, // R5 stays done above recharge
    {4'd5, 7'b1001000, 8'd2,  5'b01010}, // R5 recharge restart
    {4'd6, 7'b1001010, 8'd60, 5'b00000}, // R6 suspend across full window
    {4'd6, 7'b1001000, 8'd2,  5'b01010}, // R6 resume
    {4'd9, 7'b1001000, 8'd50, 5'b00100}, // R9 timeout below recharge
    {4'd8, 7'b1000000, 8'd2,  5'b00000}, // R8 wait after cell rises
    {4'd8, 7'b1001000, 8'd2,  5'b01010}, // R8 restart after sag
    {4'd1, 7'b0001000, 8'd1,  5'b00000}  // R1 disable
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [4:0] exp);
    logic [4:0] got;
    got = {cmd_pre, cmd_fast, flt_cur_en, stat1_on, stat2_on};
    checks++;
    if (got !== exp || cmd_off !== !(exp[4] | exp[3])) begin
      errors++;
      $display("FAIL %s: got %b off=%b expected %b off=%b", tag, got, cmd_off,
               exp, !(exp[4] | exp[3]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1 reset", 5'b00000);
    rst_n = 1'b1;
    step(1);
    check("R1 after reset release", 5'b00000);

    for (int i = 0; i < NV; i++) begin
      {chg_en, tmr_off, bat_low, bat_below_rch, term_det, temp_fault, therm_reg}
        = VEC[i][19:13];
      step(int'(VEC[i][12:5]));
      check($sformatf("R%0d row %0d", VEC[i][23:20], i), VEC[i][4:0]);
    end

    // R2 R7: conditioning window edge at full rate
    rate_scale = 8'd255; bat_low = 1; bat_below_rch = 1; chg_en = 1;
    step(5);
    check("R2 R7 last cycle of window", 5'b10011);
    step(1);
    check("R2 timeout to detection", 5'b00100);

    // R1: dropping enable clears the fault
    chg_en = 0;
    step(1);
    check("R1 enable drop clears fault", 5'b00000);

    // R11: half rate doubles the window
    rate_scale = 8'd127; chg_en = 1;
    step(9);
    check("R11 half rate still conditioning", 5'b10011);
    step(1);
    check("R11 half rate timeout", 5'b00100);

    // R10: timers and termination removed
    chg_en = 0;
    step(1);
    rate_scale = 8'd255; tmr_off = 1; chg_en = 1;
    step(30);
    check("R10 no conditioning timeout", 5'b10011);
    bat_low = 0; bat_below_rch = 0; term_det = 1;
    step(3);
    check("R10 no termination", 5'b01010);

    // R8 then R10: timeout above recharge waits, strap restarts
    tmr_off = 0; term_det = 0;
    step(45);
    check("R8 timeout above recharge waits", 5'b00000);
    tmr_off = 1;
    step(1);
    check("R10 strap clears fault", 5'b01010);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule